// File: doc/BRIEF.md
# Bit-band alias controller

This block sits between a bus master and a plain memory bus and gives every bit of two target memory regions its own word address. A single-word access that lands in one of the alias windows is translated into an access to one bit of a byte, halfword or word in the matching target region. The block fetches the target unit on a read and returns the selected bit as a 0 or 1 value.

On a write, the block runs a locked read-modify-write on the master bus. It reads the target unit, replaces the selected bit with bit 0 of the write data, and writes the unit back with the same size to the same address. The master lock stays asserted for the whole sequence, so no other master can change the unit between the read and the write-back.

The slave side takes one request at a time with a valid/ready handshake and returns a one-cycle response pulse. The master side issues requests that are held until the memory acknowledges them. Each alias window has its own decoder instance. Addresses outside every window complete at once with a zero result and cause no master traffic.

Top module: `bb_alias_ctrl`

## Requirements
- R1: An address in alias window i (window 0 alias 0x22000000 with base 0x20000000, window 1 alias 0x42000000 with base 0x40000000, each window 0x02000000 bytes) targets byte address base_i | (offset >> 5), where offset is the low 25 address bits. That address is aligned down to 2 bytes for a halfword access and to 4 bytes for a word access, and it appears on m_addr.
- R2: s_size encodes 0 = byte, 1 = halfword, 2 or 3 = word, and m_size repeats it. The bit index within the unit is offset[4:2] for a byte, offset[5:2] for a halfword and offset[6:2] for a word. On the 32-bit bus that bit is in little-endian lane position 8*m_addr[1:0] + index.
- R3: A read response carries the selected target bit in s_rdata[0], and all other response bits are zero. A write response carries zero.
- R4: A write takes only s_wdata[0]. A 1 sets the selected bit and a 0 clears it, and every other bit of the memory word is left unchanged.
- R5: A write issues exactly one master read followed by exactly one master write, both with the same address and size. A read issues exactly one master read and leaves memory unchanged.
- R6: m_lock is high on every master request of a write sequence and stays high from its read through its write-back. It is never high for a read or while idle.
- R7: s_ready is high only while idle. It goes low from acceptance through the cycle in which s_rvalid pulses, and each accepted request gets exactly one s_rvalid pulse.
- R8: A request outside every window responds with s_rdata zero and makes no master request.
- R9: Once raised, m_req, m_we, m_addr and m_size stay unchanged until m_ack.
- R10: During reset s_ready is high, and m_req, m_lock and s_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Slave request valid |
| s_ready | output | 1 | Slave can accept a request |
| s_addr | input | 32 | Alias byte address |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| s_write | input | 1 | 1 for write, 0 for read |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_rvalid | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Response data (selected bit in bit 0) |
| m_req | output | 1 | Master request, held until m_ack |
| m_we | output | 1 | Master write enable |
| m_lock | output | 1 | Bus lock over a read-modify-write |
| m_addr | output | 32 | Target byte address |
| m_size | output | 2 | Target unit size |
| m_wdata | output | 32 | Full bus word for write-back |
| m_ack | input | 1 | Memory completed the request |
| m_rdata | input | 32 | Memory read word, valid with m_ack |

## Verification
The bench builds the block with its default parameters: two windows at their default alias and base addresses and a 25-bit window offset. This puts both windows, their first and last alias words, and the 1 MB edge of each target region within reach. A memory model in the bench answers with zero, one or two wait cycles in turn, so the read-to-write-back gap and the held request are exercised with different timings. Random alias addresses of all three sizes, together with directed edge offsets, reach every lane and bit position of the bus.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int unsigned BB_AW    = 32;
  localparam int unsigned BB_DW    = 32;
  localparam int unsigned BB_POS_W = $clog2(BB_DW);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_MOD,
    ST_WR,
    ST_RESP
  } bb_state_e;

  // Fold the two-bit size code: code 3 behaves as a word.
  function automatic bb_size_e bb_norm_size(input logic [1:0] code);
    bb_size_e r;
    case (code)
      2'd0:    r = SZ_BYTE;
      2'd1:    r = SZ_HALF;
      default: r = SZ_WORD;
    endcase
    return r;
  endfunction

  // Byte address of the target unit for an alias offset.
  function automatic logic [BB_AW-1:0] bb_target(input logic [BB_AW-1:0] base,
                                                input logic [BB_AW-1:0] off,
                                                input bb_size_e sz);
    logic [BB_AW-1:0] t;
    t = base | (off >> 5);
    case (sz)
      SZ_BYTE: ;
      SZ_HALF: t[0] = 1'b0;
      default: t[1:0] = 2'b00;
    endcase
    return t;
  endfunction

  // Bit index inside the unit, from alias word-select bits offset[6:2].
  function automatic logic [BB_POS_W-1:0] bb_bit_index(input logic [4:0] wsel,
                                                     input bb_size_e sz);
    logic [BB_POS_W-1:0] idx;
    case (sz)
      SZ_BYTE: idx = {2'b00, wsel[2:0]};
      SZ_HALF: idx = {1'b0, wsel[3:0]};
      default: idx = wsel;
    endcase
    return idx;
  endfunction

  // Little-endian bus bit position of a unit bit.
  function automatic logic [BB_POS_W-1:0] bb_lane_pos(input logic [1:0] lo,
                                                    input logic [BB_POS_W-1:0] idx);
    return {lo, 3'b000} + idx;
  endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int unsigned AW        = BB_AW,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter logic [AW-1:0] ALIAS   = 32'h2200_0000,
  parameter logic [AW-1:0] BASE    = 32'h2000_0000,
  localparam int unsigned POS_W    = BB_POS_W
) (
  input  logic [AW-1:0]    addr,
  input  bb_size_e         size,
  output logic             hit,
  output logic [AW-1:0]    tgt,
  output logic [POS_W-1:0] pos
);

  logic [AW-1:0] off;

  assign off = {{(AW-SPAN_LOG2){1'b0}}, addr[SPAN_LOG2-1:0]};
  assign hit = (addr[AW-1:SPAN_LOG2] == ALIAS[AW-1:SPAN_LOG2]);
  assign tgt = bb_target(BASE, off, size);
  assign pos = bb_lane_pos(tgt[1:0], bb_bit_index(off[6:2], size));

endmodule

// File: rtl/bb_lane_unit.sv
module bb_lane_unit #(
  parameter int unsigned BUS_W = 32,
  localparam int unsigned POS_W = $clog2(BUS_W)
) (
  input  logic [BUS_W-1:0] word,
  input  logic [POS_W-1:0] pos,
  input  logic             set_val,
  output logic             bit_val,
  output logic [BUS_W-1:0] merged
);

  assign bit_val = word[pos];

  for (genvar g = 0; g < BUS_W; g++) begin : g_lane
    assign merged[g] = (pos == POS_W'(g)) ? set_val : word[g];
  end

endmodule

// File: rtl/bb_seq_fsm.sv
module bb_seq_fsm
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      s_valid,
  input  logic      req_hit,
  input  logic      op_we_q,
  input  logic      m_ack,
  output bb_state_e state_q,
  output logic      s_ready,
  output logic      s_rvalid,
  output logic      m_req,
  output logic      m_we,
  output logic      m_lock,
  output logic      ev_accept,
  output logic      ev_rd_done,
  output logic      ev_wr_done
);

  bb_state_e state_d;

  assign ev_accept  = (state_q == ST_IDLE) && s_valid;
  assign ev_rd_done = (state_q == ST_RD) && m_ack;
  assign ev_wr_done = (state_q == ST_WR) && m_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (s_valid) state_d = req_hit ? ST_RD : ST_RESP;
      ST_RD:   if (m_ack)   state_d = op_we_q ? ST_MOD : ST_RESP;
      ST_MOD:               state_d = ST_WR;
      ST_WR:   if (m_ack)   state_d = ST_RESP;
      ST_RESP:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign s_ready  = (state_q == ST_IDLE);
  assign s_rvalid = (state_q == ST_RESP);
  assign m_req    = (state_q == ST_RD) || (state_q == ST_WR);
  assign m_we     = (state_q == ST_WR);
  assign m_lock   = op_we_q &&
                    ((state_q == ST_RD) || (state_q == ST_MOD) || (state_q == ST_WR));

endmodule

// File: rtl/bb_alias_ctrl.sv
module bb_alias_ctrl
  import bb_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned AW        = BB_AW,
  parameter int unsigned DW        = BB_DW,
  parameter int unsigned SPAN_LOG2 = 25,
  parameter logic [NUM_WIN-1:0][AW-1:0] WIN_ALIAS = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][AW-1:0] WIN_BASE  = {32'h4000_0000, 32'h2000_0000},
  localparam int unsigned POS_W = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [AW-1:0] s_addr,
  input  logic [1:0]    s_size,
  input  logic          s_write,
  input  logic [DW-1:0] s_wdata,
  output logic          s_rvalid,
  output logic [DW-1:0] s_rdata,
  output logic          m_req,
  output logic          m_we,
  output logic          m_lock,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ack,
  input  logic [DW-1:0] m_rdata
);

  bb_size_e               req_size;
  logic [NUM_WIN-1:0]     win_hit;
  logic [AW-1:0]          win_tgt [NUM_WIN];
  logic [POS_W-1:0]       win_pos [NUM_WIN];
  logic                   sel_hit;
  logic [AW-1:0]          sel_tgt;
  logic [POS_W-1:0]       sel_pos;

  logic                   hit_q, we_q, wbit_q;
  logic [AW-1:0]          tgt_q;
  logic [POS_W-1:0]       pos_q;
  bb_size_e               size_q;
  logic [DW-1:0]          rd_q, mod_q;

  bb_state_e              state_q;
  logic                   ev_accept, ev_rd_done, ev_wr_done;
  logic                   lane_bit;
  logic [DW-1:0]          lane_merged;
  logic                   unused_wdata_hi;

  assign unused_wdata_hi = ^s_wdata[DW-1:1];
  assign req_size        = bb_norm_size(s_size);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bb_window_decode #(
      .AW        (AW),
      .SPAN_LOG2 (SPAN_LOG2),
      .ALIAS     (WIN_ALIAS[w]),
      .BASE      (WIN_BASE[w])
    ) u_dec (
      .addr (s_addr),
      .size (req_size),
      .hit  (win_hit[w]),
      .tgt  (win_tgt[w]),
      .pos  (win_pos[w])
    );
  end

  // Lowest-numbered window wins if windows overlap.
  always_comb begin
    sel_hit = 1'b0;
    sel_tgt = '0;
    sel_pos = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        sel_hit = 1'b1;
        sel_tgt = win_tgt[i];
        sel_pos = win_pos[i];
      end
    end
  end

  bb_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .req_hit    (sel_hit),
    .op_we_q    (we_q),
    .m_ack      (m_ack),
    .state_q    (state_q),
    .s_ready    (s_ready),
    .s_rvalid   (s_rvalid),
    .m_req      (m_req),
    .m_we       (m_we),
    .m_lock     (m_lock),
    .ev_accept  (ev_accept),
    .ev_rd_done (ev_rd_done),
    .ev_wr_done (ev_wr_done)
  );

  bb_lane_unit #(.BUS_W(DW)) u_lane (
    .word    (rd_q),
    .pos     (pos_q),
    .set_val (wbit_q),
    .bit_val (lane_bit),
    .merged  (lane_merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      we_q   <= 1'b0;
      wbit_q <= 1'b0;
      tgt_q  <= '0;
      pos_q  <= '0;
      size_q <= SZ_BYTE;
      rd_q   <= '0;
      mod_q  <= '0;
    end else begin
      if (ev_accept) begin
        hit_q  <= sel_hit;
        we_q   <= s_write;
        wbit_q <= s_wdata[0];
        tgt_q  <= sel_tgt;
        pos_q  <= sel_pos;
        size_q <= req_size;
      end
      if (ev_rd_done) rd_q <= m_rdata;
      if (state_q == ST_MOD) mod_q <= lane_merged;
    end
  end

  assign m_addr  = tgt_q;
  assign m_size  = size_q;
  assign m_wdata = mod_q;
  assign s_rdata = {{(DW-1){1'b0}}, s_rvalid & hit_q & ~we_q & lane_bit};

endmodule

// File: rtl/bb_alias_chk.sv
module bb_alias_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          s_rvalid,
  input logic [DW-1:0] s_rdata,
  input logic          m_req,
  input logic          m_we,
  input logic          m_lock,
  input logic [AW-1:0] m_addr,
  input logic [1:0]    m_size,
  input logic [DW-1:0] m_wdata,
  input logic          m_ack,
  input logic [DW-1:0] m_rdata,
  input logic          ev_rd_done
);

  logic [AW-1:0] seen_addr;
  logic [1:0]    seen_size;
  logic [DW-1:0] seen_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_addr <= '0;
      seen_size <= '0;
      seen_data <= '0;
    end else if (ev_rd_done) begin
      seen_addr <= m_addr;
      seen_size <= m_size;
      seen_data <= m_rdata;
    end
  end

  a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!m_req && !s_rvalid));

  a_r6_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !m_lock);

  a_r6_writeback_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> m_lock);

  a_r5_writeback_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> (m_addr == seen_addr && m_size == seen_size));

  a_r4_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> ($countones(m_wdata ^ seen_data) <= 1));

  a_r3_result_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> (s_rdata[DW-1:1] == '0));

  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_size)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |=> !s_rvalid);

  // R10: quiet outputs while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (s_ready && !m_req && !m_lock && !s_rvalid);
    end
  end

endmodule

bind bb_alias_ctrl bb_alias_chk #(.AW(AW), .DW(DW)) u_bb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_ready    (s_ready),
  .s_rvalid   (s_rvalid),
  .s_rdata    (s_rdata),
  .m_req      (m_req),
  .m_we       (m_we),
  .m_lock     (m_lock),
  .m_addr     (m_addr),
  .m_size     (m_size),
  .m_wdata    (m_wdata),
  .m_ack      (m_ack),
  .m_rdata    (m_rdata),
  .ev_rd_done (ev_rd_done)
);

// File: tb/test_bb_alias_ctrl.sv
`timescale 1ns/1ps
module test_bb_alias_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_addr = '0;
  logic [1:0]  s_size = '0;
  logic        s_write = 1'b0;
  logic [31:0] s_wdata = '0;
  logic        s_rvalid;
  logic [31:0] s_rdata;
  logic        m_req, m_we, m_lock;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bb_alias_ctrl i_bb_alias_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_size(s_size),
    .s_write(s_write), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  // ---------------- memory model and shadow ----------------
  logic [31:0] mem     [int unsigned];
  logic [31:0] ref_mem [int unsigned];
  int          mem_lat = 0;
  int          wcnt = 0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [1:0]  last_rd_size = '0, last_wr_size = '0;

  function automatic logic [31:0] seed_word(input int unsigned w);
    return (w * 32'h9E37_79B1) ^ 32'h5A3C_C3A5;
  endfunction

  function automatic logic [31:0] mem_get(input int unsigned w);
    if (mem.exists(w)) return mem[w];
    return seed_word(w);
  endfunction

  function automatic logic [31:0] ref_get(input int unsigned w);
    if (ref_mem.exists(w)) return ref_mem[w];
    return seed_word(w);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF << (8 * a[1:0]);
    if (sz == 2'd1) return 32'hFFFF << (16 * a[1]);
    return 32'hFFFF_FFFF;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ack <= 1'b0;
      wcnt  = 0;
    end else if (m_ack) begin
      m_ack <= 1'b0;
    end else if (m_req) begin
      if (wcnt >= mem_lat) begin
        wcnt = 0;
        m_ack <= 1'b1;
        if (m_we) begin
          logic [31:0] msk;
          msk = lane_mask(m_addr, m_size);
          mem[m_addr >> 2] = (mem_get(m_addr >> 2) & ~msk) | (m_wdata & msk);
          n_wr++;
          last_wr_addr = m_addr;
          last_wr_size = m_size;
        end else begin
          m_rdata <= mem_get(m_addr >> 2);
          n_rd++;
          last_rd_addr = m_addr;
          last_rd_size = m_size;
        end
      end else begin
        wcnt++;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench's own view of the address mapping.
  task automatic ref_map(input logic [31:0] a, input logic [1:0] sz, output bit hit,
                         output logic [31:0] tgt, output int pos, output int units);
    longint unsigned base, off;
    hit = 1;
    units = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin
      base = 64'h2000_0000; off = a - 32'h2200_0000;
    end else if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin
      base = 64'h4000_0000; off = a - 32'h4200_0000;
    end else begin
      hit = 0; tgt = '0; pos = 0;
      return;
    end
    tgt = 32'(base + off / 32);
    tgt = tgt - (tgt % units);
    pos = int'((tgt % 4) * 8 + (off / 4) % (8 * units));
  endtask

  int txn = 0;

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd);
    bit          hit;
    logic [31:0] tgt, w, got;
    int          pos, units, r0, w0, cyc;
    ref_map(a, sz, hit, tgt, pos, units);
    mem_lat = txn % 3;
    txn++;
    @(negedge clk);
    check(s_ready === 1'b1, "R7 ready while idle", 32'(s_ready), 32'd1);
    r0 = n_rd; w0 = n_wr;
    s_valid = 1'b1; s_addr = a; s_size = sz; s_write = we; s_wdata = wd;
    @(negedge clk);
    s_valid = 1'b0;
    cyc = 0;
    while (s_rvalid !== 1'b1 && cyc < 200) begin
      check(s_ready === 1'b0, "R7 ready low while busy", 32'(s_ready), 32'd0);
      if (m_req === 1'b1)
        check(m_lock === (we && hit), "R6 lock on request", 32'(m_lock), 32'(we && hit));
      @(negedge clk);
      cyc++;
    end
    check(s_rvalid === 1'b1, "R7 response pulse", 32'(s_rvalid), 32'd1);
    got = s_rdata;
    if (!hit) begin
      check(got == 32'd0, "R8 miss returns zero", got, 32'd0);
      check(n_rd == r0 && n_wr == w0, "R8 miss has no master traffic",
            32'(n_rd - r0 + n_wr - w0), 32'd0);
    end else if (!we) begin
      w = ref_get(tgt >> 2);
      check(got == 32'(w[pos]), "R3 read bit", got, 32'(w[pos]));
      check(n_rd - r0 == 1 && n_wr == w0, "R5 read makes one master read",
            32'((n_rd - r0) * 16 + (n_wr - w0)), 32'h10);
      check(last_rd_addr == tgt, "R1 target address", last_rd_addr, tgt);
      check(last_rd_size == ((sz == 2'd3) ? 2'd2 : sz), "R2 master size",
            32'(last_rd_size), 32'(sz));
      check(mem_get(tgt >> 2) == w, "R5 read leaves memory", mem_get(tgt >> 2), w);
    end else begin
      w = ref_get(tgt >> 2);
      w[pos] = wd[0];
      ref_mem[tgt >> 2] = w;
      check(got == 32'd0, "R3 write response zero", got, 32'd0);
      check(n_rd - r0 == 1 && n_wr - w0 == 1, "R5 one read then one write",
            32'((n_rd - r0) * 16 + (n_wr - w0)), 32'h11);
      check(last_rd_addr == tgt && last_wr_addr == tgt, "R1 R5 write-back address",
            last_wr_addr, tgt);
      check(last_wr_size == last_rd_size, "R5 write-back size",
            32'(last_wr_size), 32'(last_rd_size));
      check(mem_get(tgt >> 2) == w, "R4 memory after bit write", mem_get(tgt >> 2), w);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(s_ready === 1'b1 && m_req === 1'b0 && m_lock === 1'b0 && s_rvalid === 1'b0,
          "R10 reset state", {28'd0, s_ready, m_req, m_lock, s_rvalid}, 32'h8);
    rst_n = 1'b1;

    // R3 R2: directed reads at window starts and ends, every size.
    access(32'h2200_0000, 2'd0, 1'b0, '0);
    access(32'h2200_0004, 2'd1, 1'b0, '0);
    access(32'h2200_007C, 2'd2, 1'b0, '0);
    access(32'h23FF_FFFC, 2'd2, 1'b0, '0);
    access(32'h4200_0040, 2'd0, 1'b0, '0);
    access(32'h43FF_FFFC, 2'd1, 1'b0, '0);
    access(32'h4200_0064, 2'd3, 1'b0, '0);   // R2: code 3 acts as word

    // R4: set then clear, using a data word whose upper bits oppose bit 0.
    access(32'h2200_0120, 2'd0, 1'b1, 32'h0000_0001);
    access(32'h2200_0120, 2'd0, 1'b0, '0);
    access(32'h2200_0120, 2'd0, 1'b1, 32'hFFFF_FFFE);
    access(32'h2200_0120, 2'd0, 1'b0, '0);
    access(32'h4200_00F8, 2'd2, 1'b1, 32'h0000_0001);
    access(32'h4200_00F8, 2'd2, 1'b0, '0);
    access(32'h43FF_FFFC, 2'd1, 1'b1, 32'h8000_0000);
    access(32'h43FF_FFFC, 2'd1, 1'b0, '0);

    // R8: addresses outside both windows.
    access(32'h2400_0000, 2'd2, 1'b0, '0);
    access(32'h21FF_FFFC, 2'd0, 1'b1, 32'h1);
    access(32'h3000_0000, 2'd1, 1'b0, '0);

    // Mixed pseudo-random traffic over both windows, all sizes.
    x = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      x = x * 32'd1103515245 + 32'd12345;
      a = (x[31] ? 32'h4200_0000 : 32'h2200_0000) | {7'd0, x[24:2], 2'b00};
      access(a, x[26:25], x[27], {31'd0, x[28]});
      if (x[27]) access(a, x[26:25], 1'b0, '0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule